// File: doc/BRIEF.md
# EPROM Programming Sequencer

This block writes a complete image into a byte-wide, one-time or UV-erasable EPROM by driving its pins directly. It visits each address in turn, with programming supplies selected. At each address it drives the address and the byte, enables the chip and applies fixed-width program strobes. After every strobe it releases the data bus and reads the byte back. When the read-back matches, it moves to the next address. When it does not match, it strobes again, up to a fixed cap on attempts per byte. After the last address, it reads the whole array back twice: first with a high core-supply setting and then with a lower one. Any mismatch ends the run as failed.

The image arrives on a valid/ready byte stream in ascending address order. The controller takes exactly one beat per address per pass, so the source must send the image three times: once to program and once for each check pass. `src_ready` is high only while the controller waits for a byte, and it stays high until a beat is taken. A source may hold `src_valid` low for any number of cycles. Once it raises `src_valid`, it must keep it high with stable data until the controller takes the beat. Supply selection is a two-bit code plus a program-voltage enable, and the analog side is outside this block. Every timed interval is a cycle count derived from `CYC_PER_US`.

Top module: `eprom_pgm_ctrl`

## Requirements
- R1: After reset the strobes are inactive (`mem_ce_n`, `mem_oe_n`, `mem_pgm_n` high), `mem_dq_oe` is 0, `vcc_sel` is 0 (idle), `vpp_hi` is 0 and `done`/`fail` are 0.
- R2: While the array is being programmed, `vcc_sel` is 1 (programming core level) and `vpp_hi` is 1, and every program strobe occurs under these settings.
- R3: The address, driven data, data-drive enable, chip enable and supply settings stay unchanged for at least `SETUP_US*CYC_PER_US` cycles before `mem_pgm_n` falls. `mem_ce_n` is low and the data bus is driven throughout a strobe.
- R4: Each program strobe holds `mem_pgm_n` low for exactly `PULSE_US*CYC_PER_US` cycles.
- R5: After `mem_pgm_n` rises, the data stays driven for at least `HOLD_US*CYC_PER_US` cycles. `mem_oe_n` falls at least `SETUP_US*CYC_PER_US` cycles after the bus is released. `mem_dq_oe` and a low `mem_oe_n` never coincide.
- R6: Each verify read has `mem_ce_n` and `mem_oe_n` low with `mem_pgm_n` high. The number of strobes applied to an address equals the number needed before its read-back first equals the image byte, and the run then moves on to the next address.
- R7: An address that still mismatches after `MAX_TRIES` strobes ends the run with `done`=1 and `fail`=1. It receives exactly `MAX_TRIES` strobes, and no later address is fetched or strobed. A byte that verifies on exactly the last allowed strobe passes.
- R8: After the last address verifies, every address is read once with `vcc_sel`=2 and then once with `vcc_sel`=3, with `vpp_hi`=0 during both passes. The first mismatching read ends the run with `fail`=1.
- R9: The source stream delivers one beat per address per pass (three passes in total), and the number of beats taken equals the number of addresses visited. Once `src_ready` is high, it stays high until a beat is accepted.
- R10: `done` and `fail` keep their values until the next `start`, which clears both. `done` with `fail`=0 means every byte was programmed and passed both checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| src_valid | input | 1 | Image byte available |
| src_ready | output | 1 | Controller accepts the image byte this cycle |
| src_data | input | DATA_W | Image byte for the current address |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dq_out | output | DATA_W | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Read-back data from the memory bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vcc_sel | output | 2 | Core supply code: 0 idle, 1 program, 2 high check, 3 low check |
| vpp_hi | output | 1 | Program supply at programming level |
| done | output | 1 | Run finished |
| fail | output | 1 | Run finished unsuccessfully |

## Verification
A corrupted interval timer shows up within one strobe as a pulse of the wrong length or a shortened setup, hold or turnaround window. The bench measures each of these at every strobe. A wrong attempt count shows up as a per-address strobe count that differs from the memory model's needs, or as a missed or premature failure at the cap. A wrong pass or address state shows up by the end of the run: the read counts at each check supply level are wrong, a stream beat is missing or extra, or the run ends with the wrong `fail` flag.

// File: rtl/eprom_pgm_pkg.sv
package eprom_pgm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_TURN,
    ST_VERIFY,
    ST_SETTLE,
    ST_CFETCH,
    ST_CREAD
  } pgm_state_e;

  typedef enum logic [1:0] {
    SUP_IDLE   = 2'd0,
    SUP_PROG   = 2'd1,
    SUP_CHK_HI = 2'd2,
    SUP_CHK_LO = 2'd3
  } supply_e;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/pgm_interval_timer.sv
module pgm_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pgm_try_counter.sv
module pgm_try_counter #(
  parameter int MAX = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int TW = $clog2(MAX + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == TW'(MAX));
endmodule

// File: rtl/pgm_addr_walker.sv
module pgm_addr_walker #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (inc)  addr <= addr + 1'b1;
  end

  assign last = &addr;
endmodule

// File: rtl/eprom_pgm_ctrl.sv
module eprom_pgm_ctrl
  import eprom_pgm_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_US = 100,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int ACCESS_NS  = 150,
  parameter int MAX_TRIES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic [1:0]        vcc_sel,
  output logic              vpp_hi,
  output logic              done,
  output logic              fail
);
  localparam int SETUP_CYC = at_least_one(SETUP_US * CYC_PER_US);
  localparam int PULSE_CYC = at_least_one(PULSE_US * CYC_PER_US);
  localparam int HOLD_CYC  = at_least_one(HOLD_US * CYC_PER_US);
  localparam int RD_CYC    = (ACCESS_NS * CYC_PER_US + 999) / 1000 + 1;
  localparam int TMR_W     = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + RD_CYC + 1);

  pgm_state_e        st, nxt;
  supply_e           vcc_q;
  logic              vpp_q, done_q, fail_q, pass_q;
  logic [DATA_W-1:0] exp_q;

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             try_clr, try_inc, try_limit;
  logic             a_clr, a_inc, a_last;
  logic             take, match;
  logic             go_chk_hi, go_chk_lo, fin, fin_fail;

  pgm_interval_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pgm_try_counter #(.MAX(MAX_TRIES)) u_try (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .at_limit(try_limit)
  );

  pgm_addr_walker #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc), .addr(mem_addr), .last(a_last)
  );

  assign match = (mem_dq_in == exp_q);

  always_comb begin
    nxt       = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    a_clr     = 1'b0;
    a_inc     = 1'b0;
    take      = 1'b0;
    go_chk_hi = 1'b0;
    go_chk_lo = 1'b0;
    fin       = 1'b0;
    fin_fail  = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        nxt   = ST_FETCH;
        a_clr = 1'b1;
      end
      ST_FETCH: if (src_valid) begin
        take     = 1'b1;
        try_clr  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETUP_CYC - 1);
        nxt      = ST_SETUP;
      end
      ST_SETUP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(PULSE_CYC - 1);
        nxt      = ST_PULSE;
      end
      ST_PULSE: if (tmr_zero) begin
        try_inc  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HOLD_CYC - 1);
        nxt      = ST_HOLD;
      end
      ST_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETUP_CYC - 1);
        nxt      = ST_TURN;
      end
      ST_TURN: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RD_CYC - 1);
        nxt      = ST_VERIFY;
      end
      ST_VERIFY: if (tmr_zero) begin
        if (match) begin
          if (a_last) begin
            a_clr     = 1'b1;
            go_chk_hi = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = TMR_W'(SETUP_CYC - 1);
            nxt       = ST_SETTLE;
          end else begin
            a_inc = 1'b1;
            nxt   = ST_FETCH;
          end
        end else if (try_limit) begin
          fin      = 1'b1;
          fin_fail = 1'b1;
          nxt      = ST_IDLE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETUP_CYC - 1);
          nxt      = ST_SETUP;
        end
      end
      ST_SETTLE: if (tmr_zero) nxt = ST_CFETCH;
      ST_CFETCH: if (src_valid) begin
        take     = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RD_CYC - 1);
        nxt      = ST_CREAD;
      end
      ST_CREAD: if (tmr_zero) begin
        if (!match) begin
          fin      = 1'b1;
          fin_fail = 1'b1;
          nxt      = ST_IDLE;
        end else if (!a_last) begin
          a_inc = 1'b1;
          nxt   = ST_CFETCH;
        end else if (!pass_q) begin
          a_clr     = 1'b1;
          go_chk_lo = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(SETUP_CYC - 1);
          nxt       = ST_SETTLE;
        end else begin
          fin = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      vcc_q  <= SUP_IDLE;
      vpp_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      pass_q <= 1'b0;
      exp_q  <= '0;
    end else begin
      st <= nxt;
      if (take) exp_q <= src_data;
      if (st == ST_IDLE && start) begin
        vcc_q  <= SUP_PROG;
        vpp_q  <= 1'b1;
        done_q <= 1'b0;
        fail_q <= 1'b0;
        pass_q <= 1'b0;
      end
      if (go_chk_hi) begin
        vcc_q <= SUP_CHK_HI;
        vpp_q <= 1'b0;
      end
      if (go_chk_lo) begin
        vcc_q  <= SUP_CHK_LO;
        pass_q <= 1'b1;
      end
      if (fin) begin
        vcc_q  <= SUP_IDLE;
        vpp_q  <= 1'b0;
        done_q <= 1'b1;
        fail_q <= fin_fail;
      end
    end
  end

  assign src_ready  = (st == ST_FETCH) || (st == ST_CFETCH);
  assign mem_dq_out = exp_q;
  assign mem_dq_oe  = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);
  assign mem_pgm_n  = (st != ST_PULSE);
  assign mem_oe_n   = !((st == ST_VERIFY) || (st == ST_CREAD));
  assign mem_ce_n   = !((st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD) ||
                        (st == ST_TURN) || (st == ST_VERIFY) || (st == ST_CREAD));
  assign vcc_sel    = vcc_q;
  assign vpp_hi     = vpp_q;
  assign done       = done_q;
  assign fail       = fail_q;
endmodule

// File: rtl/eprom_pgm_ctrl_chk.sv
module eprom_pgm_ctrl_chk
  import eprom_pgm_pkg::*;
#(
  parameter int PULSE_CYC = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       src_valid,
  input logic       src_ready,
  input logic       mem_dq_oe,
  input logic       mem_ce_n,
  input logic       mem_oe_n,
  input logic       mem_pgm_n,
  input logic [1:0] vcc_sel,
  input logic       vpp_hi,
  input logic       done
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (!mem_pgm_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_strobe_context_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (!mem_ce_n && mem_dq_oe));

  assert_strobe_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (vcc_sel == SUP_PROG && vpp_hi));

  assert_verify_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_pgm_n && !mem_ce_n));

  assert_low_check_vpp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_sel == SUP_CHK_LO) |-> !vpp_hi);

  assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (low_cnt < PULSE_CYC));

  assert_width_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (low_cnt == PULSE_CYC));

  assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !src_valid) |=> src_ready);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind eprom_pgm_ctrl eprom_pgm_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_valid(src_valid), .src_ready(src_ready),
  .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
  .vcc_sel(vcc_sel), .vpp_hi(vpp_hi), .done(done)
);

// File: tb/sim_eprom_pgm_ctrl.sv
module sim_eprom_pgm_ctrl;
  localparam int AW = 4, NB = 16, CPU = 1;
  localparam int SETUP_C = 2, PULSE_C = 100, HOLD_C = 2, MAXT = 25;

  logic clk, rst_n, start, src_valid, src_ready;
  logic [7:0] src_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_hi, done, fail;
  logic [1:0] vcc_sel;

  eprom_pgm_ctrl #(.ADDR_W(AW), .DATA_W(8), .CYC_PER_US(CPU), .PULSE_US(100),
    .SETUP_US(2), .HOLD_US(2), .ACCESS_NS(150), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
    .vcc_sel(vcc_sel), .vpp_hi(vpp_hi), .done(done), .fail(fail));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] mem [NB];
  logic [7:0] img [NB];
  int need [NB];
  int pcnt [NB];
  int lo_fault, hi_fault;
  int beats, rd_hi, rd_lo, viol_setup, viol_width, viol_hold, viol_turn, viol_sup;
  int n_chk, n_fail;
  bit feeder_busy;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
    (mem[mem_addr] ^ (((vcc_sel == 2'd3 && int'(mem_addr) == lo_fault) ||
                       (vcc_sel == 2'd2 && int'(mem_addr) == hi_fault)) ? 8'h01 : 8'h00)) : 8'hFF;

  // cell model: a cell takes its value after need[] strobes
  initial forever begin
    @(posedge mem_pgm_n);
    if (mem_ce_n === 1'b0 && vpp_hi === 1'b1 && mem_dq_oe === 1'b1) begin
      pcnt[mem_addr] = pcnt[mem_addr] + 1;
      if (pcnt[mem_addr] >= need[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_dq_out;
    end
  end

  // pin timing monitor, sampled at the falling clock edge
  initial begin
    logic [AW+8+5-1:0] prev_vec, cur_vec;
    logic prev_pgm, prev_oe, prev_dqoe;
    int stable, low, since_rise, since_rel;
    prev_vec = '0; prev_pgm = 1'b1; prev_oe = 1'b1; prev_dqoe = 1'b0;
    stable = 0; low = 0; since_rise = 100; since_rel = 100;
    forever begin
      @(negedge clk);
      cur_vec = {mem_addr, mem_dq_out, mem_dq_oe, mem_ce_n, vcc_sel, vpp_hi};
      stable = (cur_vec != prev_vec) ? 0 : stable + 1;
      since_rise++;
      since_rel++;
      if (!mem_pgm_n) low++;
      if (prev_pgm && !mem_pgm_n) begin
        if (stable < SETUP_C) viol_setup++;
        if (vcc_sel != 2'd1 || !vpp_hi) viol_sup++;
      end
      if (!prev_pgm && mem_pgm_n) begin
        if (low != PULSE_C) viol_width++;
        low = 0;
        since_rise = 0;
      end
      if (prev_dqoe && !mem_dq_oe) begin
        if (since_rise < HOLD_C) viol_hold++;
        since_rel = 0;
      end
      if (prev_oe && !mem_oe_n && !mem_ce_n) begin
        if (vpp_hi && since_rel < SETUP_C) viol_turn++;
        if (vcc_sel == 2'd2) rd_hi++;
        if (vcc_sel == 2'd3) rd_lo++;
        if ((vcc_sel == 2'd2 || vcc_sel == 2'd3) && vpp_hi) viol_sup++;
      end
      if (mem_dq_oe && !mem_oe_n) viol_turn++;
      prev_vec = cur_vec; prev_pgm = mem_pgm_n; prev_oe = mem_oe_n; prev_dqoe = mem_dq_oe;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int exp_pulses(input logic [7:0] b, input int n);
    return (b == 8'hFF) ? 1 : n;
  endfunction

  task automatic feeder();
    feeder_busy = 1'b1;
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < NB; a++) begin
        int idle;
        idle = int'($urandom % 3);
        src_valid = 1'b0;
        for (int k = 0; k < idle; k++) @(negedge clk);
        src_valid = 1'b1;
        src_data  = img[a];
        while (!src_ready && !done) @(negedge clk);
        if (done) begin
          src_valid = 1'b0;
          feeder_busy = 1'b0;
          return;
        end
        beats++;
        @(negedge clk);
      end
    end
    src_valid = 1'b0;
    feeder_busy = 1'b0;
  endtask

  task automatic run(input string tag);
    int c;
    for (int a = 0; a < NB; a++) begin
      mem[a] = 8'hFF;
      pcnt[a] = 0;
    end
    beats = 0; rd_hi = 0; rd_lo = 0;
    viol_setup = 0; viol_width = 0; viol_hold = 0; viol_turn = 0; viol_sup = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && fail == 1'b0, {tag, " R10 start clears flags"}, int'({done, fail}), 0);
    fork feeder(); join_none
    c = 0;
    while (!done && c < 60000) begin
      @(negedge clk);
      c++;
    end
    chk(done == 1'b1, {tag, " watchdog"}, c, 60000);
    c = 0;
    while (feeder_busy && c < 100) begin
      @(negedge clk);
      c++;
    end
    chk(viol_setup == 0, {tag, " R3 setup before strobe"}, viol_setup, 0);
    chk(viol_width == 0, {tag, " R4 strobe width"}, viol_width, 0);
    chk(viol_hold == 0 && viol_turn == 0, {tag, " R5 hold and turnaround"}, viol_hold + viol_turn, 0);
    chk(viol_sup == 0, {tag, " R2 supply codes"}, viol_sup, 0);
  endtask

  initial begin
    bit ok;
    int bad;
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0;
    start = 1'b0; src_valid = 1'b0; src_data = 8'h00;
    lo_fault = -1; hi_fault = -1; feeder_busy = 1'b0;
    for (int a = 0; a < NB; a++) begin
      mem[a] = 8'hFF; img[a] = 8'h00; need[a] = 1; pcnt[a] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1 strobes idle", int'({mem_ce_n, mem_oe_n, mem_pgm_n}), 7);
    chk(!mem_dq_oe && vcc_sel == 2'd0 && !vpp_hi, "R1 bus and supply idle",
        int'({mem_dq_oe, vcc_sel, vpp_hi}), 0);
    chk(!done && !fail, "R1 flags clear", int'({done, fail}), 0);

    // random image, random strobe needs
    for (int a = 0; a < NB; a++) begin
      img[a]  = 8'($urandom);
      need[a] = 1 + int'($urandom % 4);
    end
    img[2] = 8'hFF;
    run("A");
    chk(fail == 1'b0, "A R10 pass", fail, 0);
    bad = 0;
    for (int a = 0; a < NB; a++) if (mem[a] != img[a]) bad++;
    chk(bad == 0, "A R6 image written", bad, 0);
    bad = 0;
    for (int a = 0; a < NB; a++) if (pcnt[a] != exp_pulses(img[a], need[a])) bad++;
    chk(bad == 0, "A R6 strobes per address", bad, 0);
    chk(rd_hi == NB && rd_lo == NB, "A R8 check reads", rd_hi * 100 + rd_lo, NB * 101);
    chk(beats == 3 * NB, "A R9 beats", beats, 3 * NB);
    repeat (20) @(negedge clk);
    chk(done && !fail, "A R10 flags held", int'({done, fail}), 2);

    // cap edge: exactly MAX strobes passes
    for (int a = 0; a < NB; a++) begin
      img[a] = 8'($urandom) & 8'h7F;
      need[a] = 1;
    end
    need[5] = MAXT;
    run("B");
    chk(fail == 1'b0, "B R7 pass on last strobe", fail, 0);
    chk(pcnt[5] == MAXT, "B R7 strobe count", pcnt[5], MAXT);

    // one beyond the cap
    need[5] = 1;
    img[9] = 8'h5A;
    need[9] = MAXT + 1;
    run("C");
    chk(fail == 1'b1, "C R7 fail flag", fail, 1);
    chk(pcnt[9] == MAXT, "C R7 capped strobes", pcnt[9], MAXT);
    ok = 1'b1;
    for (int a = 10; a < NB; a++) if (pcnt[a] != 0 || mem[a] != 8'hFF) ok = 1'b0;
    chk(ok, "C R7 later addresses untouched", int'(ok), 1);
    chk(beats == 10, "C R9 beats", beats, 10);
    chk(rd_hi == 0, "C R8 no check pass", rd_hi, 0);

    // low-level check fault
    need[9] = 2;
    lo_fault = 3;
    run("D");
    chk(fail == 1'b1, "D R8 low check fails", fail, 1);
    chk(rd_hi == NB && rd_lo == 4, "D R8 reads before stop", rd_hi * 100 + rd_lo, NB * 100 + 4);

    // high-level check fault on the last address
    lo_fault = -1;
    hi_fault = NB - 1;
    run("E");
    chk(fail == 1'b1, "E R8 high check fails", fail, 1);
    chk(rd_hi == NB && rd_lo == 0, "E R8 stops before low pass", rd_hi * 100 + rd_lo, NB * 100);

    // clean run after a failure
    hi_fault = -1;
    run("F");
    chk(fail == 1'b0, "F R10 clean after failure", fail, 0);
    chk(beats == 3 * NB, "F R9 beats", beats, 3 * NB);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule